// File: doc/BRIEF.md
# Pipelined CORDIC Twiddle-Factor Generator

This block supplies the complex rotation coefficients that the multipliers of an 8192-point radix-2 FFT consume. It does not read them from a stored table. It computes them at run time from a 13-bit twiddle index k, where the angle is θ = 2πk/8192. For each index it returns cos θ and −sin θ as signed 16-bit fixed-point words. One request is taken every clock. Each result appears a fixed number of cycles later, together with a valid strobe.

The two top index bits select the quadrant. The CORDIC rotator therefore only works on the residual angle inside the first quarter turn. The rotator has sixteen micro-rotation stages, one register each. Its start vector is preloaded with the inverse of the CORDIC gain, so no multiplier is needed at the output. A final stage does the following:
- rounds the guard bits away;
- clips the result to the symmetric 16-bit range;
- maps the first-quadrant pair back to the requested quadrant;
- forces exact values on the four axis angles.

Each multiplier stage of the transform (for example the 256-point delay-feedback part and the 32-point pipelined part) drives its own instance with its own index sequence.

Top module: `twid_cordic_gen`

## Requirements
- R1: For index k (13-bit unsigned) and θ = 2πk/8192, out_cos is within 2 LSB of 32768·cos θ and out_nsin is within 2 LSB of −32768·sin θ. Both reference values are first clipped to ±32767.
- R2: A request sampled with req_valid high at a rising clock edge produces out_valid high, carrying its result, exactly 18 rising edges later. out_valid is low in every cycle that no request maps to. Index values presented with req_valid low produce no output.
- R3: Requests on consecutive cycles each produce a result on consecutive cycles, in the order they were issued (one result per clock).
- R4: The axis indices give exact values:
  - k=0 gives (32767, 0);
  - k=2048 gives (0, −32767);
  - k=4096 gives (−32767, 0);
  - k=6144 gives (0, 32767).
- R5: Quadrant folding uses k[12:11]. For an index that is not a multiple of 2048:
  - quadrant 0 gives out_cos ≥ 0 and out_nsin ≤ 0;
  - quadrant 1 gives out_cos ≤ 0 and out_nsin ≤ 0;
  - quadrant 2 gives out_cos ≤ 0 and out_nsin ≥ 0;
  - quadrant 3 gives out_cos ≥ 0 and out_nsin ≥ 0.
- R6: Neither output ever takes the value −32768. Both stay in [−32767, 32767].
- R7: rst is synchronous and active high. While it is sampled high, and on the first edge after it, out_valid is low. Requests in flight when reset is applied never emerge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all registers on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| req_valid | input | 1 | A twiddle index is presented this cycle |
| req_index | input | 13 | Twiddle index k, angle 2πk/8192 |
| out_valid | output | 1 | out_cos and out_nsin hold a result |
| out_cos | output | 16 | cos θ, two's complement, 1.0 scaled to 32768 and clipped |
| out_nsin | output | 16 | −sin θ, same format |

## Verification
The bench drives the following index patterns:
- **Full sweep.** All 8192 indices back to back. This exposes any angle-table, gain or rounding error anywhere on the circle, and shows that one result per clock comes out in order.
- **Axis set.** The four axis indices, sent with gaps between them. This separates the exact-override path from plain CORDIC convergence, which would leave a one-LSB residue.
- **Quadrant edges.** Indices just either side of each quadrant boundary. These catch a wrong quadrant mapping or sign swap, which would be invisible at interior points.
- **Scattered strides with toggling valid.** A scattered index stream with valid switching on and off, and junk indices on the idle cycles. This tests the latency alignment and that idle cycles produce nothing.

Two reset checks complete the set:
- holding reset while requests are presented;
- applying reset while results are still in flight.

// File: rtl/twid_pkg.sv
package twid_pkg;

    localparam int IDX_W     = 13;
    localparam int OUT_W     = 16;
    localparam int GUARD     = 6;
    localparam int STAGES    = 16;
    localparam int ANG_FRAC  = 8;

    localparam int RES_W     = IDX_W - 2;
    localparam int DW        = OUT_W + GUARD + 2;
    localparam int ZW        = RES_W + ANG_FRAC + 2;
    localparam int LATENCY   = STAGES + 2;
    localparam int MAXV_INT  = (1 << (OUT_W - 1)) - 1;
    localparam int QUARTER_U = 1 << (RES_W + ANG_FRAC);
    localparam int ONE_D     = 1 << (OUT_W - 1 + GUARD);

    typedef logic signed [DW-1:0]    dat_t;
    typedef logic signed [ZW-1:0]    ang_t;
    typedef logic signed [OUT_W-1:0] out_t;

    typedef struct packed {
        logic       vld;
        logic [1:0] quad;
        logic       axis;
        dat_t       x;
        dat_t       y;
        ang_t       z;
    } lane_t;

    localparam real  PI_R   = 3.14159265358979323846;
    localparam dat_t HALF_D = dat_t'(1 << (GUARD - 1));
    localparam dat_t MAXV_D = dat_t'(MAXV_INT);
    localparam out_t MAXV_O = out_t'(MAXV_INT);

    function automatic real atan_pow2(input int i);
        real x, x2, xp, acc, sgn;
        if (i == 0) return PI_R / 4.0;
        x = 1.0;
        for (int n = 0; n < i; n++) x = x / 2.0;
        x2 = x * x; xp = x; acc = 0.0; sgn = 1.0;
        for (int n = 0; n < 32; n++) begin
            acc = acc + sgn * xp / real'(2 * n + 1);
            xp  = xp * x2;
            sgn = -sgn;
        end
        return acc;
    endfunction

    function automatic int atan_units(input int i);
        real scale;
        scale = real'(QUARTER_U) / (PI_R / 2.0);
        return $rtoi(atan_pow2(i) * scale + 0.5);
    endfunction

    function automatic real sqrt_r(input real v);
        real s;
        s = v;
        for (int n = 0; n < 40; n++) s = 0.5 * (s + v / s);
        return s;
    endfunction

    function automatic int gain_preload();
        real g, p;
        g = 1.0; p = 1.0;
        for (int i = 0; i < STAGES; i++) begin
            g = g / sqrt_r(1.0 + p * p);
            p = p / 2.0;
        end
        return $rtoi(g * real'(ONE_D) + 0.5);
    endfunction

    function automatic out_t round_sat(input dat_t v);
        dat_t t;
        t = (v + HALF_D) >>> GUARD;
        if (t > MAXV_D)       return MAXV_O;
        else if (t < -MAXV_D) return -MAXV_O;
        return out_t'(t);
    endfunction

endpackage

// File: rtl/twid_fold.sv
module twid_fold
    import twid_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_index,
    output lane_t            dout
);

    localparam dat_t X0 = dat_t'(gain_preload());

    always_ff @(posedge clk) begin
        if (rst) dout.vld <= 1'b0;
        else     dout.vld <= req_valid;
        dout.quad <= req_index[IDX_W-1 -: 2];
        dout.axis <= (req_index[RES_W-1:0] == '0);
        dout.x    <= X0;
        dout.y    <= '0;
        dout.z    <= ang_t'({req_index[RES_W-1:0], {ANG_FRAC{1'b0}}});
    end

endmodule

// File: rtl/twid_stage.sv
module twid_stage
    import twid_pkg::*;
#(
    parameter int IDX = 0
)
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t din,
    output lane_t dout
);

    localparam ang_t STEP = ang_t'(atan_units(IDX));

    dat_t xsh;
    dat_t ysh;

    always_comb begin
        xsh = $signed(din.x) >>> IDX;
        ysh = $signed(din.y) >>> IDX;
    end

    always_ff @(posedge clk) begin
        if (rst) dout.vld <= 1'b0;
        else     dout.vld <= din.vld;
        dout.quad <= din.quad;
        dout.axis <= din.axis;
        if (!din.z[ZW-1]) begin
            dout.x <= din.x - ysh;
            dout.y <= din.y + xsh;
            dout.z <= din.z - STEP;
        end else begin
            dout.x <= din.x + ysh;
            dout.y <= din.y - xsh;
            dout.z <= din.z + STEP;
        end
    end

endmodule

// File: rtl/twid_post.sv
module twid_post
    import twid_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t din,
    output logic  vld,
    output out_t  cos_q,
    output out_t  nsin_q
);

    out_t rc, rs, c, s;

    always_comb begin
        rc = round_sat(din.x);
        rs = round_sat(din.y);
        if (din.axis) begin
            rc = MAXV_O;
            rs = '0;
        end
        case (din.quad)
            2'd0:    begin c = rc;  s = rs;  end
            2'd1:    begin c = -rs; s = rc;  end
            2'd2:    begin c = -rc; s = -rs; end
            default: begin c = rs;  s = -rc; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) vld <= 1'b0;
        else     vld <= din.vld;
        cos_q  <= c;
        nsin_q <= -s;
    end

endmodule

// File: rtl/twid_cordic_gen.sv
module twid_cordic_gen
    import twid_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [IDX_W-1:0]        req_index,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_cos,
    output logic signed [OUT_W-1:0] out_nsin
);

    lane_t pipe [STAGES+1];

    twid_fold i_fold (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_index (req_index),
        .dout      (pipe[0])
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_rot
        twid_stage #(.IDX(g)) i_stage (
            .clk  (clk),
            .rst  (rst),
            .din  (pipe[g]),
            .dout (pipe[g+1])
        );
    end

    twid_post i_post (
        .clk    (clk),
        .rst    (rst),
        .din    (pipe[STAGES]),
        .vld    (out_valid),
        .cos_q  (out_cos),
        .nsin_q (out_nsin)
    );

endmodule

// File: rtl/twid_cordic_chk.sv
module twid_cordic_chk
    import twid_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [IDX_W-1:0]        req_index,
    input  logic                    out_valid,
    input  logic signed [OUT_W-1:0] out_cos,
    input  logic signed [OUT_W-1:0] out_nsin
);

    logic             vsr [LATENCY];
    logic [IDX_W-1:0] isr [LATENCY];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LATENCY; i++) vsr[i] <= 1'b0;
        end else begin
            vsr[0] <= req_valid;
            for (int i = 1; i < LATENCY; i++) vsr[i] <= vsr[i-1];
        end
        isr[0] <= req_index;
        for (int i = 1; i < LATENCY; i++) isr[i] <= isr[i-1];
    end

    logic [IDX_W-1:0] k_out;
    logic             interior;
    longint           rad2;

    always_comb begin
        k_out    = isr[LATENCY-1];
        interior = (k_out[RES_W-1:0] != '0);
        rad2     = longint'(out_cos) * longint'(out_cos) + longint'(out_nsin) * longint'(out_nsin);
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid == vsr[LATENCY-1]);

    p_no_neg_full_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_cos != out_t'(-MAXV_INT - 1)) && (out_nsin != out_t'(-MAXV_INT - 1)));

    p_zero_index_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && k_out == '0) |-> (out_cos == MAXV_O) && (out_nsin == '0));

    p_quarter_index_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && k_out == IDX_W'(QUARTER_U >> ANG_FRAC)) |-> (out_cos == '0) && (out_nsin == -MAXV_O));

    p_sign_q0_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && interior && k_out[IDX_W-1 -: 2] == 2'd0) |-> (out_cos >= 0) && (out_nsin <= 0));

    p_sign_q2_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && interior && k_out[IDX_W-1 -: 2] == 2'd2) |-> (out_cos <= 0) && (out_nsin >= 0));

    p_radius_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (rad2 >= 64'd1073479696) && (rad2 <= 64'd1074069584));

    p_reset_clears_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

endmodule

bind twid_cordic_gen twid_cordic_chk i_chk (.*);

// File: tb/test_twid_cordic_gen.sv
`timescale 1ns/1ps
module test_twid_cordic_gen;

    localparam int  LAT  = 18;
    localparam int  MAXV = 32767;
    localparam real PI   = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic [12:0]        req_index = '0;
    logic               out_valid;
    logic signed [15:0] out_cos;
    logic signed [15:0] out_nsin;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic        lst_vld [128];
    logic [12:0] lst_idx [128];

    always #5 clk = ~clk;

    twid_cordic_gen i_twid_cordic_gen (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_index (req_index),
        .out_valid (out_valid),
        .out_cos   (out_cos),
        .out_nsin  (out_nsin)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int rnd(input real r);
        if (r >= 0.0) return $rtoi(r + 0.5);
        return -$rtoi(-r + 0.5);
    endfunction

    function automatic int clip(input int v);
        if (v > MAXV)  return MAXV;
        if (v < -MAXV) return -MAXV;
        return v;
    endfunction

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic check_sample(input int k);
        real a;
        int  ec, es, gc, gs, q;
        a  = 2.0 * PI * real'(k) / 8192.0;
        ec = clip(rnd(32768.0 * $cos(a)));
        es = clip(rnd(-32768.0 * $sin(a)));
        gc = int'(out_cos);
        gs = int'(out_nsin);
        q  = k / 2048;
        if (k % 2048 == 0) begin
            chk(gc == ec, "R4", $sformatf("axis cos k=%0d", k), gc, ec);
            chk(gs == es, "R4", $sformatf("axis nsin k=%0d", k), gs, es);
        end else begin
            chk(absd(gc, ec) <= 2, "R1", $sformatf("cos k=%0d", k), gc, ec);
            chk(absd(gs, es) <= 2, "R1", $sformatf("nsin k=%0d", k), gs, es);
            case (q)
                0: chk(gc >= 0 && gs <= 0, "R5", $sformatf("signs q0 k=%0d", k), gc, ec);
                1: chk(gc <= 0 && gs <= 0, "R5", $sformatf("signs q1 k=%0d", k), gc, ec);
                2: chk(gc <= 0 && gs >= 0, "R5", $sformatf("signs q2 k=%0d", k), gc, ec);
                default: chk(gc >= 0 && gs >= 0, "R5", $sformatf("signs q3 k=%0d", k), gc, ec);
            endcase
        end
        chk(gc >= -MAXV && gs >= -MAXV, "R6", $sformatf("range k=%0d", k), (gc < gs) ? gc : gs, -MAXV);
    endtask

    // drives lst_* for n cycles and checks every output cycle until drained
    task automatic run_list(input string req, input int n);
        for (int m = 0; m < n + LAT + 3; m++) begin
            bit ex;
            @(negedge clk);
            ex = (m >= LAT) && (m - LAT < n) && lst_vld[m-LAT];
            chk(out_valid == ex, req, $sformatf("out_valid slot %0d", m), int'(out_valid), int'(ex));
            if (ex && out_valid) check_sample(int'(lst_idx[m-LAT]));
            if (m < n) begin
                req_valid = lst_vld[m];
                req_index = lst_vld[m] ? lst_idx[m] : 13'h1555;
            end else begin
                req_valid = 1'b0;
                req_index = 13'h0AAA;
            end
        end
    endtask

    task automatic t_reset_hold();
        rst = 1'b1;
        for (int m = 0; m < 6; m++) begin
            @(negedge clk);
            if (m >= 1) chk(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
            req_valid = 1'b1;
            req_index = 13'(m * 311);
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        req_valid = 1'b0;
        for (int m = 0; m < LAT + 3; m++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R7", "no output after reset", int'(out_valid), 0);
        end
    endtask

    task automatic t_axis();
        int ks[7] = '{0, 77, 2048, 99, 99, 4096, 6144};
        bit vs[7] = '{1, 0, 1, 0, 0, 1, 1};
        for (int i = 0; i < 7; i++) begin
            lst_idx[i] = 13'(ks[i]);
            lst_vld[i] = vs[i];
        end
        run_list("R4", 7);
    endtask

    task automatic t_edges();
        int ks[14] = '{1, 2047, 2049, 4095, 4097, 6143, 6145, 8191,
                       1024, 3072, 5120, 7168, 2, 8190};
        for (int i = 0; i < 14; i++) begin
            lst_idx[i] = 13'(ks[i]);
            lst_vld[i] = 1'b1;
        end
        run_list("R5", 14);
    endtask

    task automatic t_strides();
        for (int i = 0; i < 48; i++) begin
            lst_idx[i] = 13'((i * i * 37 + i * 13 + (i % 8) * 256) % 8192);
            lst_vld[i] = (i % 3 != 2);
        end
        run_list("R2", 48);
    endtask

    task automatic t_sweep();
        for (int m = 0; m < 8192 + LAT + 3; m++) begin
            bit ex;
            @(negedge clk);
            ex = (m >= LAT) && (m - LAT < 8192);
            chk(out_valid == ex, "R3", $sformatf("sweep valid slot %0d", m), int'(out_valid), int'(ex));
            if (ex && out_valid) check_sample(m - LAT);
            req_valid = (m < 8192);
            req_index = 13'(m);
        end
        req_valid = 1'b0;
    endtask

    task automatic t_reset_midflight();
        for (int m = 0; m < 5; m++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_index = 13'(100 + m * 900);
        end
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < LAT + 6; m++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R7", "flushed request emerged", int'(out_valid), 0);
        end
    endtask

    initial begin
        t_reset_hold();
        t_axis();
        t_edges();
        t_strides();
        t_sweep();
        t_reset_midflight();
        t_axis();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule